// File: doc/BRIEF.md
# Signed Integer to Single-Precision Float Converter

This block turns a two's-complement integer into a 32-bit binary floating-point word with a sign bit, an 8-bit biased exponent and a 23-bit stored fraction. It takes the absolute value of the input and finds the highest set bit with a priority encoder. It then shifts the magnitude so that this bit lands on the hidden-one position of a 24-bit significand.

Magnitudes that need more than 24 significant bits cannot be held exactly. The bits shifted out below the significand become a guard bit, a round bit and a sticky bit, which is the OR of all lower bits. A 2-bit mode input selects how these bits round the significand. When rounding overflows the significand, the exponent is bumped by one.

One result word and an inexact flag are registered per accepted input. They appear one clock after `valid_i` and stay unchanged until the next accepted input.

Top module: `int_to_float`

## Requirements
- R1: An input of 0 produces the all-zero word (+0) with `inexact_o` low, in every mode.
- R2: Any input whose magnitude is at most 2^24 converts exactly. `inexact_o` is low, and the value decodes back to the same integer.
- R3: For a nonzero input, result bit 31 equals input bit 31. Bits 30:23 hold 127 plus the floor of log2 of the rounded magnitude. Bits 22:0 hold the significand without its leading one.
- R4: Every nonzero result has a biased exponent in the range 127 to 158.
- R5: Mode 2'b00 rounds to the nearest value. An exact halfway case goes to the neighbour with an even (zero) significand LSB.
- R6: Mode 2'b01 rounds toward zero: the dropped bits are discarded.
- R7: Mode 2'b11 rounds toward +infinity. An inexact positive value rounds up in magnitude, and an inexact negative value is truncated.
- R8: Mode 2'b10 rounds toward -infinity. An inexact negative value rounds up in magnitude, and an inexact positive value is truncated.
- R9: When rounding carries out of the 24-bit significand, the fraction becomes 0 and the exponent rises by one. For example, 0x7FFFFFFF in mode 2'b00 gives 0x4F000000.
- R10: Input 0x80000000 converts exactly to 0xCF000000 (-2^31) with `inexact_o` low.
- R11: `inexact_o` is high exactly when some bit of the magnitude below the kept 24-bit significand is nonzero.
- R12: `valid_o` is `valid_i` delayed by one clock. While `valid_i` is low, `result_o` and `inexact_o` hold their values.
- R13: Some integers of magnitude above 2^24 do not survive conversion and decoding back. For example, 16777217 in mode 2'b00 comes back as 16777216.
- R14: While `rst_ni` is low, `valid_o`, `result_o` and `inexact_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Input word is present this cycle |
| data_i | input | 32 | Signed integer to convert |
| mode_i | input | 2 | Rounding direction: 00 nearest-even, 01 toward zero, 10 toward -inf, 11 toward +inf |
| valid_o | output | 1 | Result registered from the previous cycle's input |
| result_o | output | 32 | Packed single-precision value |
| inexact_o | output | 1 | Some dropped bit was nonzero |

## Verification
The bench works at the edges where a rounding unit usually breaks.

Exact halfway ties just above 2^24 come in both significand parities. A design that ignores the LSB or the sticky bit would round every tie the same way.

Inputs of all ones force a carry out of the significand. A design that misses the renormalisation would emit a wrong exponent or a nonzero fraction.

The most negative integer and zero cover the magnitude corner cases. Negative and positive inexact values under the two directed modes catch a sign swap in the round-up decision.

Exact values at every bit position catch an off-by-one in the exponent or the shift. Decoding converted words back to integers shows the loss above 2^24.

// File: rtl/i2f_pkg.sv
package i2f_pkg;
  typedef enum logic [1:0] {
    RM_NEAR_EVEN = 2'b00,
    RM_TO_ZERO   = 2'b01,
    RM_DOWN      = 2'b10,
    RM_UP        = 2'b11
  } rnd_mode_e;
endpackage

// File: rtl/i2f_lead_one.sv
module i2f_lead_one #(
  parameter int W     = 32,
  parameter int POS_W = $clog2(W)
) (
  input  logic [W-1:0]     vec_i,
  output logic [POS_W-1:0] pos_o
);
  // highest set bit wins; returns 0 for an all-zero vector
  always_comb begin
    pos_o = '0;
    for (int i = 0; i < W; i++) begin
      if (vec_i[i]) pos_o = POS_W'(i);
    end
  end
endmodule

// File: rtl/i2f_round.sv
module i2f_round
  import i2f_pkg::*;
(
  input  logic      lsb_i,
  input  logic      guard_i,
  input  logic      rnd_i,
  input  logic      sticky_i,
  input  logic      neg_i,
  input  rnd_mode_e mode_i,
  output logic      up_o,
  output logic      inexact_o
);
  assign inexact_o = guard_i | rnd_i | sticky_i;

  always_comb begin
    unique case (mode_i)
      RM_NEAR_EVEN: up_o = guard_i & (rnd_i | sticky_i | lsb_i);
      RM_TO_ZERO:   up_o = 1'b0;
      RM_DOWN:      up_o = neg_i & inexact_o;
      RM_UP:        up_o = ~neg_i & inexact_o;
      default:      up_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/int_to_float.sv
module int_to_float
  import i2f_pkg::*;
#(
  parameter int INT_W  = 32,
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  localparam int OUT_W = 1 + EXP_W + FRAC_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [INT_W-1:0] data_i,
  input  logic [1:0]       mode_i,
  output logic             valid_o,
  output logic [OUT_W-1:0] result_o,
  output logic             inexact_o
);
  localparam int SIG_W  = FRAC_W + 1;
  localparam int DROP_W = INT_W - SIG_W;   // needs >= 3
  localparam int POS_W  = $clog2(INT_W);
  localparam int BIAS   = (1 << (EXP_W - 1)) - 1;

  logic             neg;
  logic [INT_W-1:0] mag, norm;
  logic [POS_W-1:0] lead;
  logic [SIG_W-1:0] sig;
  logic             guard, rnd, sticky, up, inx;
  logic [SIG_W:0]   sum;
  logic             carry, is_zero;
  logic [EXP_W-1:0] exp_f;
  logic [FRAC_W-1:0] frac;
  logic [OUT_W-1:0] result_d;

  assign neg     = data_i[INT_W-1];
  assign mag     = neg ? (~data_i + 1'b1) : data_i;
  assign is_zero = (mag == '0);

  i2f_lead_one #(.W(INT_W), .POS_W(POS_W)) u_lead (
    .vec_i (mag),
    .pos_o (lead)
  );

  assign norm   = mag << (POS_W'(INT_W - 1) - lead);
  assign sig    = norm[INT_W-1 -: SIG_W];
  assign guard  = norm[DROP_W-1];
  assign rnd    = norm[DROP_W-2];
  assign sticky = |norm[DROP_W-3:0];

  i2f_round u_round (
    .lsb_i     (sig[0]),
    .guard_i   (guard),
    .rnd_i     (rnd),
    .sticky_i  (sticky),
    .neg_i     (neg),
    .mode_i    (rnd_mode_e'(mode_i)),
    .up_o      (up),
    .inexact_o (inx)
  );

  assign sum   = {1'b0, sig} + (SIG_W+1)'(up);
  assign carry = sum[SIG_W];
  assign frac  = carry ? '0 : sum[FRAC_W-1:0];
  assign exp_f = EXP_W'(BIAS) + EXP_W'(lead) + EXP_W'(carry);

  assign result_d = is_zero ? '0 : {neg, exp_f, frac};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o   <= 1'b0;
      result_o  <= '0;
      inexact_o <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        result_o  <= result_d;
        inexact_o <= inx & ~is_zero;
      end
    end
  end
endmodule

// File: rtl/int_to_float_chk.sv
module int_to_float_chk #(
  parameter int INT_W  = 32,
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  localparam int OUT_W = 1 + EXP_W + FRAC_W
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             valid_i,
  input logic [INT_W-1:0] data_i,
  input logic             valid_o,
  input logic [OUT_W-1:0] result_o,
  input logic             inexact_o
);
  localparam int BIAS = (1 << (EXP_W - 1)) - 1;
  localparam longint EXACT_LIM = longint'(1) << (FRAC_W + 1);

  longint abs_in;
  logic [EXP_W-1:0] exp_o;
  assign abs_in = data_i[INT_W-1] ? ((longint'(1) << INT_W) - longint'(data_i))
                                  : longint'(data_i);
  assign exp_o  = result_o[OUT_W-2 -: EXP_W];

  a_r12_valid_up: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  a_r12_valid_dn: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);
  a_r12_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(result_o) && $stable(inexact_o)));
  a_r1_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && data_i == '0) |=> (result_o == '0 && !inexact_o));
  a_r10_most_neg: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && data_i == {1'b1, {(INT_W-1){1'b0}}}) |=>
    (result_o[OUT_W-1] && exp_o == EXP_W'(BIAS + INT_W - 1) &&
     result_o[FRAC_W-1:0] == '0 && !inexact_o));
  a_r2_exact_small: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && abs_in <= EXACT_LIM) |=> !inexact_o);
  a_r3_sign: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && data_i != '0) |=> (result_o[OUT_W-1] == $past(data_i[INT_W-1])));
  a_r4_exp_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && result_o != '0) |->
    (exp_o >= EXP_W'(BIAS) && exp_o <= EXP_W'(BIAS + INT_W - 1)));
endmodule

bind int_to_float int_to_float_chk #(
  .INT_W(INT_W), .EXP_W(EXP_W), .FRAC_W(FRAC_W)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .valid_i   (valid_i),
  .data_i    (data_i),
  .valid_o   (valid_o),
  .result_o  (result_o),
  .inexact_o (inexact_o)
);

// File: tb/int_to_float_tb.sv
module int_to_float_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [31:0] data_i = '0;
  logic [1:0]  mode_i = '0;
  logic        valid_o;
  logic [31:0] result_o;
  logic        inexact_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  int_to_float u_dut (
    .clk_i, .rst_ni, .valid_i, .data_i, .mode_i,
    .valid_o, .result_o, .inexact_o
  );

  // arithmetic reference: quotient / remainder against powers of two
  function automatic void ref_conv(input logic [31:0] a, input logic [1:0] m,
                                   output logic [31:0] f, output bit inx);
    longint mag, q, rem, half, scale;
    int e;
    bit neg, up;
    neg = a[31];
    mag = neg ? ((longint'(1) << 32) - longint'({32'b0, a})) : longint'({32'b0, a});
    f = '0; inx = 0;
    if (mag == 0) return;
    e = 0;
    while ((longint'(1) << (e + 1)) <= mag) e++;
    if (e <= 23) begin
      q = mag << (23 - e); rem = 0; half = 1;
    end else begin
      scale = longint'(1) << (e - 23);
      q = mag / scale; rem = mag % scale; half = scale / 2;
    end
    inx = (rem != 0);
    case (m)
      2'b00: up = (rem > half) || (rem == half && rem != 0 && q[0]);
      2'b01: up = 0;
      2'b10: up = neg && inx;
      default: up = !neg && inx;
    endcase
    q = q + longint'(up);
    if (q == (longint'(1) << 24)) begin q = longint'(1) << 23; e++; end
    f = {neg, 8'(127 + e), 23'(q - (longint'(1) << 23))};
  endfunction

  function automatic longint decode_mag(input logic [31:0] f);
    longint q;
    int e;
    if (f[30:0] == '0) return 0;
    e = int'(f[30:23]) - 127;
    q = (longint'(1) << 23) | longint'(f[22:0]);
    return (e >= 23) ? (q << (e - 23)) : (q >> (23 - e));
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp_v);
    n_tests++;
    if (act !== exp_v) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp_v);
    end
  endtask

  task automatic conv(input logic [31:0] a, input logic [1:0] m, input string req);
    logic [31:0] ef;
    bit ei;
    ref_conv(a, m, ef, ei);
    @(negedge clk_i);
    data_i = a; mode_i = m; valid_i = 1'b1;
    @(negedge clk_i);
    check(req, result_o, ef);
    check({req, " inexact (R11)"}, {31'b0, inexact_o}, {31'b0, ei});
    check({req, " valid (R12)"}, {31'b0, valid_o}, 32'd1);
  endtask

  initial begin
    repeat (CLK_PERIOD * 20000) @(posedge clk_i);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] seed, snap, v, ef;
    bit ei;
    longint back;
    repeat (3) @(negedge clk_i);
    // R14: reset state
    check("R14 valid", {31'b0, valid_o}, 32'd0);
    check("R14 result", result_o, 32'd0);
    check("R14 inexact", {31'b0, inexact_o}, 32'd0);
    rst_ni = 1'b1;

    // R1: zero in every mode
    for (int m = 0; m < 4; m++) conv(32'd0, 2'(m), "R1 zero");
    // R10: most negative integer
    conv(32'h8000_0000, 2'b00, "R10 most negative");
    check("R10 literal", result_o, 32'hCF00_0000);
    // R9: carry out of significand
    conv(32'h7FFF_FFFF, 2'b00, "R9 carry");
    check("R9 literal", result_o, 32'h4F00_0000);
    conv(32'h7FFF_FFFF, 2'b01, "R6 toward zero");
    check("R6 literal", result_o, 32'h4EFF_FFFF);
    // R5: ties, even and odd LSB
    conv(32'd16777217, 2'b00, "R5 tie stays even");
    check("R5 literal low", result_o, 32'h4B80_0000);
    conv(32'd16777219, 2'b00, "R5 tie goes even");
    check("R5 literal high", result_o, 32'h4B80_0002);
    conv(32'd16777221, 2'b00, "R5 tie stays even 2");
    // R7 / R8: directed modes with both signs
    conv(32'd16777217, 2'b11, "R7 pos up");
    check("R7 literal", result_o, 32'h4B80_0001);
    conv(-32'sd16777217, 2'b11, "R7 neg truncates");
    conv(-32'sd16777217, 2'b10, "R8 neg up");
    check("R8 literal", result_o, 32'hCB80_0001);
    conv(32'd16777217, 2'b10, "R8 pos truncates");

    // R2 / R3: every bit position, both signs, all modes
    for (int k = 0; k < 31; k++)
      for (int m = 0; m < 4; m++) begin
        conv(32'd1 << k, 2'(m), "R3 power of two");
        conv(-(32'd1 << k), 2'(m), "R3 negative power");
        conv((32'd1 << k) | 32'd1, 2'(m), "R2/R3 low bit set");
        conv((32'd1 << (k + 1)) - 32'd1, 2'(m), "R9/R3 all ones");
      end
    // dense sweep across the 2^24 boundary and at the top
    for (int d = -200; d <= 200; d++)
      for (int m = 0; m < 4; m++) begin
        conv(32'(32'sd16777216 + d), 2'(m), "R5/R6/R7/R8 near 2^24");
        conv(32'(-32'sd16777216 - d), 2'(m), "R5/R6/R7/R8 near -2^24");
      end
    for (int d = 0; d < 128; d++)
      for (int m = 0; m < 4; m++) begin
        conv(32'h7FFF_FFFF - 32'(d), 2'(m), "R9 top range");
        conv(32'h8000_0000 + 32'(d), 2'(m), "R4 bottom range");
      end
    // pseudo-random spread over magnitudes
    seed = 32'h1234_5678;
    for (int i = 0; i < 1500; i++) begin
      seed = seed * 32'd1664525 + 32'd1013904223;
      v = seed >> seed[4:0];
      if (seed[5]) v = -v;
      conv(v, seed[7:6], "R3/R11 random");
    end

    // R12: hold while valid low
    conv(32'd12345, 2'b00, "R12 setup");
    snap = result_o;
    @(negedge clk_i);
    valid_i = 1'b0; data_i = 32'hDEAD_BEEF; mode_i = 2'b11;
    @(negedge clk_i);
    check("R12 valid low", {31'b0, valid_o}, 32'd0);
    check("R12 result held", result_o, snap);
    check("R12 inexact held", {31'b0, inexact_o}, 32'd0);

    // R13 / R2: decode back to integer
    conv(32'd16777216, 2'b00, "R13 exact at 2^24");
    back = decode_mag(result_o);
    check("R2 round trip 2^24", 32'(back), 32'd16777216);
    conv(32'd16777217, 2'b00, "R13 lossy");
    back = decode_mag(result_o);
    check("R13 round trip lost", 32'(back), 32'd16777216);
    conv(32'd123456789, 2'b01, "R13 lossy 2");
    ref_conv(32'd123456789, 2'b01, ef, ei);
    back = decode_mag(result_o);
    check("R13 differs from input", {31'b0, (back != 123456789)}, 32'd1);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule